// File: doc/BRIEF.md
# Auxiliary-Channel Request Sequencer with I2C Session Tracking

This block executes requests arriving over a display link's auxiliary channel. A request carries a command, an address, a byte count and a byte buffer. Native commands walk a 1 MiB byte-wide register bus one address at a time. The I2C-over-auxiliary commands become a series of byte-level operations on an I2C master command port. The port accepts four operations: start (address and direction), send byte (returns acknowledge), receive byte, and stop.

Middle-of-transaction (MOT) commands can leave an I2C session open between requests. A later MOT request to the same target in the same direction continues that session without a new start. A change of target or direction closes the session and reopens it. Plain I2C commands always close any open session before they begin, and close their own session when they finish.

A requester drives `req_valid` for one cycle while the block is idle. Write bytes are fetched from the requester's buffer through `buf_idx`/`buf_wdata`. Read bytes are returned through `rd_we`/`buf_idx`/`rd_data`. Completion is signalled by a one-cycle `done` pulse together with the reply code.

Top module: `aux_i2c_seq`

## Requirements
- R1: Command codes are 4'b1000 native write, 4'b1001 native read, 4'b0000 I2C write, 4'b0001 I2C read, 4'b0100 MOT write and 4'b0101 MOT read. Reply codes are 2'd0 ACK, 2'd1 AUX NACK and 2'd2 I2C NACK. A native request accesses byte i at the request address plus i, modulo 2^20. A write takes its data from buffer index i, and a read writes the returned byte to buffer index i. The reply is ACK when every byte succeeds.
- R2: A native access that returns a bus error ends the request with AUX NACK. No further register-bus access follows it.
- R3: I2C operations are coded 0 start, 1 send, 2 receive and 3 stop. The target address is request address bits 6:0, and the direction bit is 1 for reads. For a plain I2C command, an open session is first closed with a stop. A start to the target follows.
- R4: When the start of a plain I2C command is not acknowledged, the reply is I2C NACK. No data byte and no stop follow, and the session is closed.
- R5: A plain I2C read receives exactly the requested number of bytes into buffer indices 0 upward. It then issues a stop and replies ACK.
- R6: A plain I2C write sends the buffer bytes in order and stops at the first byte that is not acknowledged. A stop is issued whether the write succeeds or fails. The reply is I2C NACK on failure and ACK otherwise.
- R7: A MOT command issues a start when no session is open. It issues a stop and then a start when the open session has a different target address or direction.
- R8: A MOT command whose target and direction match the open session issues no start. MOT commands never issue a stop at the end of a successful request; the session stays open, and its target and direction are recorded.
- R9: A MOT write byte that is not acknowledged causes a stop and an I2C NACK reply, and closes the session. A MOT read receives every requested byte and replies ACK.
- R10: When the start of a MOT command is not acknowledged, the reply is I2C NACK and the session is closed.
- R11: Any other command code replies AUX NACK and causes no register-bus or I2C activity.
- R12: A zero-length request performs only its address phase. A native request of length zero replies ACK with no access. An I2C request of length zero performs its start or continuation and any stops its type requires. Its reply depends only on the address acknowledge.
- R13: `done` is high for exactly one cycle per request, with `reply` valid from that cycle. `busy` is high from acceptance until `done`, and `req_valid` is ignored while `busy` is high. After reset the block is idle with no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_cmd | input | 4 | Command code |
| req_addr | input | ADDR_W | Register-bus or I2C target address |
| req_len | input | LEN_W | Byte count |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion strobe |
| reply | output | 2 | Reply code |
| buf_idx | output | LEN_W | Current buffer byte index |
| buf_wdata | input | 8 | Buffer byte at buf_idx |
| rd_we | output | 1 | Store rd_data at buf_idx |
| rd_data | output | 8 | Byte read from either bus |
| rb_valid | output | 1 | Register-bus access request |
| rb_we | output | 1 | Register-bus write |
| rb_addr | output | ADDR_W | Register-bus byte address |
| rb_wdata | output | 8 | Register-bus write data |
| rb_ready | input | 1 | Register-bus access complete |
| rb_err | input | 1 | Register-bus error, with rb_ready |
| rb_rdata | input | 8 | Register-bus read data |
| i2c_valid | output | 1 | I2C operation request |
| i2c_op | output | 2 | I2C operation code |
| i2c_rd | output | 1 | Direction for start |
| i2c_addr | output | I2C_AW | Target address for start |
| i2c_wdata | output | 8 | Byte for send |
| i2c_ready | input | 1 | I2C operation complete |
| i2c_nack | input | 1 | Not acknowledged, with i2c_ready |
| i2c_rdata | input | 8 | Received byte, with i2c_ready |

## Verification
The bench sweeps every command code across a session-opening target, an absent target and a second target, with lengths zero, one and three. It also alternates a stalling responder. The session state therefore arrives in every combination of open, closed, matching and mismatching. A design that compared only the address would keep a session across a direction change and omit the stop and start. A design that forgot to close the session after a plain command or a failed start would wrongly continue the next MOT request. Directed cases check the following: error on the second native byte, which must stop the walk; address wrap at the top of the 20-bit space; a refused write byte mid-buffer, which needs a stop in both plain and MOT forms; zero-length continuation, which must produce no bus activity at all; and a request pulse during busy, which must leave no trace.

// File: rtl/aux_i2c_seq.sv
module aux_i2c_seq #(
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 5,
  parameter int I2C_AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              done,
  output logic [1:0]        reply,
  output logic [LEN_W-1:0]  buf_idx,
  input  logic [7:0]        buf_wdata,
  output logic              rd_we,
  output logic [7:0]        rd_data,
  output logic              rb_valid,
  output logic              rb_we,
  output logic [ADDR_W-1:0] rb_addr,
  output logic [7:0]        rb_wdata,
  input  logic              rb_ready,
  input  logic              rb_err,
  input  logic [7:0]        rb_rdata,
  output logic              i2c_valid,
  output logic [1:0]        i2c_op,
  output logic              i2c_rd,
  output logic [I2C_AW-1:0] i2c_addr,
  output logic [7:0]        i2c_wdata,
  input  logic              i2c_ready,
  input  logic              i2c_nack,
  input  logic [7:0]        i2c_rdata
);
  localparam logic [1:0] RP_ACK = 2'd0, RP_AUXN = 2'd1, RP_I2CN = 2'd2;
  localparam logic [1:0] OP_START = 2'd0, OP_SEND = 2'd1, OP_RECV = 2'd2, OP_STOP = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_NAT, S_PRESTOP, S_START, S_XFER, S_ENDSTOP} st_t;

  st_t               st;
  logic              mot_q, rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q, cnt;
  logic              sess_open, last_rd;
  logic [I2C_AW-1:0] last_addr;
  logic [1:0]        pend;

  wire c_nat   = req_cmd[3:1] == 3'b100;
  wire c_plain = req_cmd[3:1] == 3'b000;
  wire c_mot   = req_cmd[3:1] == 3'b010;
  wire cont    = sess_open && (req_addr[I2C_AW-1:0] == last_addr) && (req_cmd[0] == last_rd);
  wire last_by = cnt == len_q - 1'b1;

  assign busy      = st != S_IDLE;
  assign buf_idx   = cnt;
  assign rb_valid  = st == S_NAT;
  assign rb_we     = !rd_q;
  assign rb_addr   = addr_q + ADDR_W'(cnt);
  assign rb_wdata  = buf_wdata;
  assign i2c_valid = st inside {S_PRESTOP, S_START, S_XFER, S_ENDSTOP};
  assign i2c_op    = (st == S_START) ? OP_START : (st == S_XFER) ? (rd_q ? OP_RECV : OP_SEND) : OP_STOP;
  assign i2c_rd    = rd_q;
  assign i2c_addr  = addr_q[I2C_AW-1:0];
  assign i2c_wdata = buf_wdata;
  assign rd_we     = rd_q && ((st == S_XFER && i2c_ready) || (st == S_NAT && rb_ready && !rb_err));
  assign rd_data   = (st == S_NAT) ? rb_rdata : i2c_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      mot_q     <= 1'b0;
      rd_q      <= 1'b0;
      addr_q    <= '0;
      len_q     <= '0;
      cnt       <= '0;
      sess_open <= 1'b0;
      last_rd   <= 1'b0;
      last_addr <= '0;
      pend      <= RP_ACK;
      done      <= 1'b0;
      reply     <= RP_ACK;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          mot_q  <= req_cmd[2];
          rd_q   <= req_cmd[0];
          addr_q <= req_addr;
          len_q  <= req_len;
          cnt    <= '0;
          if (c_nat) begin
            if (req_len == '0) begin done <= 1'b1; reply <= RP_ACK; end
            else st <= S_NAT;
          end else if (c_plain) begin
            st <= sess_open ? S_PRESTOP : S_START;
          end else if (c_mot) begin
            if (cont) begin
              if (req_len == '0) begin done <= 1'b1; reply <= RP_ACK; end
              else st <= S_XFER;
            end else st <= sess_open ? S_PRESTOP : S_START;
          end else begin
            done  <= 1'b1;
            reply <= RP_AUXN;
          end
        end
        S_NAT: if (rb_ready) begin
          if (rb_err) begin
            st <= S_IDLE; done <= 1'b1; reply <= RP_AUXN;
          end else if (last_by) begin
            st <= S_IDLE; done <= 1'b1; reply <= RP_ACK;
          end else cnt <= cnt + 1'b1;
        end
        S_PRESTOP: if (i2c_ready) begin
          sess_open <= 1'b0;
          st        <= S_START;
        end
        S_START: if (i2c_ready) begin
          if (i2c_nack) begin
            sess_open <= 1'b0;
            st <= S_IDLE; done <= 1'b1; reply <= RP_I2CN;
          end else begin
            sess_open <= 1'b1;
            if (mot_q) begin
              last_addr <= addr_q[I2C_AW-1:0];
              last_rd   <= rd_q;
            end
            if (len_q != '0) st <= S_XFER;
            else if (mot_q) begin
              st <= S_IDLE; done <= 1'b1; reply <= RP_ACK;
            end else begin
              pend <= RP_ACK; st <= S_ENDSTOP;
            end
          end
        end
        S_XFER: if (i2c_ready) begin
          if (!rd_q && i2c_nack) begin
            pend <= RP_I2CN; st <= S_ENDSTOP;
          end else if (last_by) begin
            if (mot_q) begin
              st <= S_IDLE; done <= 1'b1; reply <= RP_ACK;
            end else begin
              pend <= RP_ACK; st <= S_ENDSTOP;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_ENDSTOP: if (i2c_ready) begin
          sess_open <= 1'b0;
          st <= S_IDLE; done <= 1'b1; reply <= pend;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && rb_ready && !rb_err) |=> (!rb_valid || rb_addr == $past(rb_addr) + ADDR_W'(1)));

  p_err_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && rb_ready && rb_err) |=> (done && reply == RP_AUXN && !rb_valid));

  p_send_nack_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_valid && i2c_ready && i2c_op == OP_SEND && i2c_nack) |=> (i2c_valid && i2c_op == OP_STOP));

  p_start_nack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_valid && i2c_ready && i2c_op == OP_START && i2c_nack) |=> (done && reply == RP_I2CN && !i2c_valid));

  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !rb_valid && !i2c_valid));
endmodule

// File: tb/aux_i2c_seq_bench.sv
`timescale 1ns/1ps
module aux_i2c_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [3:0]  req_cmd = '0;
  logic [19:0] req_addr = '0;
  logic [4:0]  req_len = '0;
  logic busy, done, rd_we, rb_valid, rb_we, i2c_valid, i2c_rd;
  logic [1:0]  reply, i2c_op;
  logic [4:0]  buf_idx;
  logic [7:0]  buf_wdata, rd_data, rb_wdata, i2c_wdata, rb_rdata, i2c_rdata;
  logic [19:0] rb_addr;
  logic [6:0]  i2c_addr;
  logic rb_ready, rb_err, i2c_ready, i2c_nack;

  logic [7:0]  wbuf [0:31];
  logic [19:0] err_addr = 20'h7FFFF;
  logic        slow = 1'b0, gate = 1'b1;
  logic [7:0]  recv_cnt = '0;
  logic [31:0] lg [0:63];
  logic [31:0] ex [0:63];
  int log_n = 0, exp_n = 0;
  int nchk = 0, nerr = 0;

  logic        m_open = 1'b0, m_rd = 1'b0;
  logic [6:0]  m_a = '0;
  logic [7:0]  m_recv = '0;
  logic [1:0]  exp_rep;
  string       tag;

  aux_i2c_seq u_aux_i2c_seq (
    .clk, .rst_n, .req_valid, .req_cmd, .req_addr, .req_len, .busy, .done, .reply,
    .buf_idx, .buf_wdata, .rd_we, .rd_data, .rb_valid, .rb_we, .rb_addr, .rb_wdata,
    .rb_ready, .rb_err, .rb_rdata, .i2c_valid, .i2c_op, .i2c_rd, .i2c_addr, .i2c_wdata,
    .i2c_ready, .i2c_nack, .i2c_rdata);

  assign buf_wdata = wbuf[buf_idx];
  assign rb_ready  = rb_valid & gate;
  assign rb_err    = rb_addr == err_addr;
  assign rb_rdata  = rb_addr[7:0] ^ 8'h5A;
  assign i2c_ready = i2c_valid & gate;
  assign i2c_nack  = (i2c_op == 2'd0 && i2c_addr == 7'h33) || (i2c_op == 2'd1 && i2c_wdata == 8'hEE);
  assign i2c_rdata = 8'hC0 + recv_cnt;

  function automatic logic [31:0] ei(input logic [1:0] op, input logic r, input logic [6:0] ad, input logic [7:0] d);
    return {2'b01, 12'b0, op, r, ad, d};
  endfunction
  function automatic logic [31:0] en(input logic we, input logic [19:0] ad, input logic [7:0] d);
    return {2'b10, 1'b0, we, ad, d};
  endfunction
  function automatic logic [31:0] er(input logic [4:0] ix, input logic [7:0] d);
    return {2'b11, 17'b0, ix, d};
  endfunction

  always @(posedge clk) begin
    gate <= slow ? ~gate : 1'b1;
    if (i2c_valid && i2c_ready) begin
      case (i2c_op)
        2'd0: lg[log_n] = ei(2'd0, i2c_rd, i2c_addr, 8'h00);
        2'd1: lg[log_n] = ei(2'd1, 1'b0, 7'h0, i2c_wdata);
        2'd2: lg[log_n] = ei(2'd2, 1'b0, 7'h0, 8'h00);
        default: lg[log_n] = ei(2'd3, 1'b0, 7'h0, 8'h00);
      endcase
      if (log_n < 63) log_n++;
      if (i2c_op == 2'd2) recv_cnt <= recv_cnt + 8'd1;
    end
    if (rb_valid && rb_ready) begin
      lg[log_n] = en(rb_we, rb_addr, rb_we ? rb_wdata : 8'h00);
      if (log_n < 63) log_n++;
    end
    if (rd_we) begin
      lg[log_n] = er(buf_idx, rd_data);
      if (log_n < 63) log_n++;
    end
  end

  task automatic chk(input logic ok, input string t, input string what, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual %h expected %h", t, what, act, expv);
    end
  endtask

  task automatic push(input logic [31:0] e);
    ex[exp_n] = e;
    exp_n++;
  endtask

  task automatic model(input logic [3:0] c, input logic [19:0] a, input int len);
    logic [6:0] a7;
    logic rd, cont;
    a7 = a[6:0];
    rd = c[0];
    exp_n = 0;
    if (c == 4'h8 || c == 4'h9) begin
      tag = (len == 0) ? "R12" : "R1";
      exp_rep = 2'd0;
      for (int i = 0; i < len; i++) begin
        logic [19:0] ad;
        ad = a + 20'(i);
        push(en(!rd, ad, rd ? 8'h00 : wbuf[i]));
        if (ad == err_addr) begin exp_rep = 2'd1; tag = "R2"; break; end
        if (rd) push(er(5'(i), ad[7:0] ^ 8'h5A));
      end
    end else if (c == 4'h0 || c == 4'h1) begin
      tag = m_open ? "R3" : (rd ? "R5" : "R6");
      if (m_open) push(ei(2'd3, 1'b0, 7'h0, 8'h00));
      m_open = 1'b0;
      push(ei(2'd0, rd, a7, 8'h00));
      if (a7 == 7'h33) begin exp_rep = 2'd2; tag = "R4"; return; end
      if (len == 0) tag = "R12";
      exp_rep = 2'd0;
      for (int i = 0; i < len; i++) begin
        if (rd) begin
          push(ei(2'd2, 1'b0, 7'h0, 8'h00));
          push(er(5'(i), 8'hC0 + m_recv));
          m_recv = m_recv + 8'd1;
        end else begin
          push(ei(2'd1, 1'b0, 7'h0, wbuf[i]));
          if (wbuf[i] == 8'hEE) begin exp_rep = 2'd2; tag = "R6"; break; end
        end
      end
      push(ei(2'd3, 1'b0, 7'h0, 8'h00));
    end else if (c == 4'h4 || c == 4'h5) begin
      cont = m_open && a7 == m_a && rd == m_rd;
      tag = (!cont && m_open) ? "R7" : "R8";
      if (!cont) begin
        if (m_open) push(ei(2'd3, 1'b0, 7'h0, 8'h00));
        m_open = 1'b0;
        push(ei(2'd0, rd, a7, 8'h00));
        if (a7 == 7'h33) begin exp_rep = 2'd2; tag = "R10"; return; end
        m_open = 1'b1;
        m_a = a7;
        m_rd = rd;
      end
      if (len == 0) tag = "R12";
      exp_rep = 2'd0;
      for (int i = 0; i < len; i++) begin
        if (rd) begin
          push(ei(2'd2, 1'b0, 7'h0, 8'h00));
          push(er(5'(i), 8'hC0 + m_recv));
          m_recv = m_recv + 8'd1;
        end else begin
          push(ei(2'd1, 1'b0, 7'h0, wbuf[i]));
          if (wbuf[i] == 8'hEE) begin
            push(ei(2'd3, 1'b0, 7'h0, 8'h00));
            m_open = 1'b0;
            exp_rep = 2'd2;
            tag = "R9";
            break;
          end
        end
      end
    end else begin
      tag = "R11";
      exp_rep = 2'd1;
    end
  endtask

  task automatic run(input logic [3:0] c, input logic [19:0] a, input int len, input logic inject);
    int waitc;
    logic bad;
    int bi;
    model(c, a, len);
    @(negedge clk);
    log_n = 0;
    req_cmd = c; req_addr = a; req_len = 5'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (inject) begin
      tag = "R13";
      req_cmd = 4'h9; req_addr = 20'h00100; req_len = 5'd2; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    waitc = 0;
    while (!done && waitc < 300) begin
      @(negedge clk);
      waitc++;
    end
    chk(done, tag, "completion", 32'(done), 32'd1);
    chk(reply == exp_rep, tag, "reply", 32'(reply), 32'(exp_rep));
    @(negedge clk);
    chk(!done && !busy, "R13", "done one cycle then idle", {30'b0, done, busy}, 32'd0);
    bad = 1'b0;
    bi = 0;
    for (int i = 0; i < 64; i++) begin
      if (!bad && i < exp_n && (i >= log_n || lg[i] != ex[i])) begin bad = 1'b1; bi = i; end
    end
    if (log_n != exp_n)
      chk(1'b0, tag, "bus event count", 32'(log_n), 32'(exp_n));
    else
      chk(!bad, tag, $sformatf("bus event %0d", bi), lg[bi], ex[bi]);
  endtask

  task automatic fill(input logic [7:0] seed);
    for (int i = 0; i < 32; i++) wbuf[i] = (8'h10 + 8'(i)) ^ {4'h0, seed[3:0]};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    fill(8'h0);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rb_valid && !i2c_valid, "R13", "reset idle",
        {28'b0, busy, done, rb_valid, i2c_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int c = 0; c < 16; c++) begin
      slow = c[0];
      fill(8'(c));
      for (int ai = 0; ai < 4; ai++) begin
        for (int li = 0; li < 3; li++) begin
          logic [19:0] ad;
          ad = (ai == 1) ? 20'h00033 : (ai == 3) ? 20'hA0051 : 20'h00050;
          run(4'(c), ad, (li == 2) ? 3 : li, 1'b0);
        end
      end
    end

    slow = 1'b0;
    fill(8'h3);
    run(4'h5, 20'h00050, 2, 1'b0);
    run(4'h5, 20'h00050, 1, 1'b0);
    run(4'h5, 20'h00050, 0, 1'b0);
    run(4'h4, 20'h00050, 1, 1'b0);
    run(4'h4, 20'h00052, 1, 1'b0);
    run(4'h1, 20'h00052, 2, 1'b0);

    err_addr = 20'h00201;
    run(4'h9, 20'h00200, 4, 1'b0);
    run(4'h8, 20'h00200, 4, 1'b0);
    err_addr = 20'h7FFFF;
    run(4'h8, 20'hFFFFE, 4, 1'b0);
    run(4'h9, 20'hFFFFF, 3, 1'b0);

    wbuf[1] = 8'hEE;
    run(4'h0, 20'h00050, 3, 1'b0);
    run(4'h4, 20'h00050, 3, 1'b0);
    run(4'h4, 20'h00050, 1, 1'b0);
    run(4'h4, 20'h00050, 3, 1'b0);
    fill(8'h5);

    slow = 1'b1;
    run(4'h1, 20'h00050, 3, 1'b1);
    run(4'h5, 20'h00050, 3, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule